// File: doc/BRIEF.md
# Dual-Lag Autocorrelation Frame Detector

This block watches a stream of complex baseband samples and signals when a received frame begins. Two delayed autocorrelators share the stream. One compares each sample with the sample 16 positions earlier, which finds the repeating short training pattern of an OFDM preamble. The other uses a 20-sample lag, which finds the repeating start of a DSSS preamble. Each correlator keeps a running complex correlation sum and a running energy sum over a window as long as its lag. It declares a detection when the squared correlation magnitude, normalised by the squared energy, exceeds that correlator's own threshold.

A detection sets a sticky flag for that waveform. The flag stays high until the receiver that owns it pulses its clear line. That receiver does this when it rejects the preamble, or when the frame ends. The two flags are independent. Samples are taken only in cycles where the valid input is high.

Top module: `pkt_detect_dual`

## Requirements
- R1: After reset both detect flags are low.
- R2: For the OFDM correlator with lag L=16, after n accepted samples x[0..n-1], the correlation is C = sum over k in [n-16, n-1] with k >= 16 of x[k]·conj(x[k-16]). The energy is E = sum over k in [n-16, n-1] with k >= 0 of |x[k]|².
- R3: The DSSS correlator computes C and E in the same way with lag L=20 and a 20-sample window.
- R4: A correlator finds a hit when |C|²·256 > thr·E², where thr is its 8-bit unsigned threshold input (ρ² in units of 1/256). The comparison is strict.
- R5: A window with zero energy never gives a hit, even with a threshold of 0.
- R6: A flag cannot rise until at least 2·L samples have been accepted since reset.
- R7: A raised flag stays high whatever the later samples are, until its clear input is pulsed.
- R8: Pulsing one clear input lowers only that flag. If a clear and a set fall in the same cycle, the clear wins.
- R9: The hit from an accepted sample shows on the flag after the second rising edge that follows the edge accepting the sample. After the first of those edges the flag still holds its old value.
- R10: Cycles with the valid input low change no sum and produce no decision, whatever is on the sample inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Sample strobe |
| sampleI | input | SAMPLE_W | In-phase sample, signed |
| sampleQ | input | SAMPLE_W | Quadrature sample, signed |
| thrOfdm | input | THR_W | Lag-16 threshold, ρ² scaled by 2^THR_W |
| thrDsss | input | THR_W | Lag-20 threshold, ρ² scaled by 2^THR_W |
| clrOfdm | input | 1 | Release pulse from the OFDM receiver |
| clrDsss | input | 1 | Release pulse from the DSSS receiver |
| detOfdm | output | 1 | Sticky lag-16 detection flag |
| detDsss | output | 1 | Sticky lag-20 detection flag |

## Verification
A corrupt delay-line tap or a running sum that is not fully cancelled leaves a lasting offset. The detect decisions then drift away from the direct window sums from the next few samples onward. The bench compares both flags after every sample against freshly computed sums, so such a fault shows within one window length. A fault in the fill counter or the clear priority shows as a flag edge one sample too early or one cycle too late. This is caught because the flags are sampled both between the two edges and after them.

// File: rtl/pktdet_pkg.sv
package pktdet_pkg;
  // Strobes from a detector's control to its datapath
  typedef struct packed {
    logic shiftEn;  // accept the current sample into the window
    logic evalEn;   // sums were refreshed last edge, decide now
  } acorrStrobe_t;

  localparam int NUM_DET = 2;
  localparam int DET_OFDM = 0;
  localparam int DET_DSSS = 1;
endpackage

// File: rtl/acorr_datapath.sv
module acorr_datapath
  import pktdet_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LAG      = 16,
  parameter int THR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  acorrStrobe_t               strobe,
  input  logic signed [SAMPLE_W-1:0] sampleI,
  input  logic signed [SAMPLE_W-1:0] sampleQ,
  input  logic [THR_W-1:0]           thrIn,
  output logic                       hit
);
  localparam int PW = 2 * SAMPLE_W + 1;          // one product term
  localparam int CW = PW + $clog2(LAG) + 1;      // window sums
  localparam int LW = 2 * CW + THR_W + 1;        // comparison width

  logic signed [SAMPLE_W-1:0] dlyI [LAG];
  logic signed [SAMPLE_W-1:0] dlyQ [LAG];
  logic signed [PW-1:0]       dlyPRe [LAG];
  logic signed [PW-1:0]       dlyPIm [LAG];
  logic signed [PW-1:0]       dlyE [LAG];

  logic signed [PW-1:0] curI, curQ, oldI, oldQ;
  logic signed [PW-1:0] pRe, pIm, eTerm;
  logic signed [CW-1:0] cRe, cIm, eSum;

  // Product of the new sample with the conjugate of the one LAG back
  always_comb begin
    curI  = PW'(sampleI);
    curQ  = PW'(sampleQ);
    oldI  = PW'(dlyI[LAG-1]);
    oldQ  = PW'(dlyQ[LAG-1]);
    pRe   = curI * oldI + curQ * oldQ;
    pIm   = curQ * oldI - curI * oldQ;
    eTerm = curI * curI + curQ * curQ;
  end

  // Delay lines: raw samples, product terms and energy terms
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < LAG; k++) begin
        dlyI[k]   <= '0;
        dlyQ[k]   <= '0;
        dlyPRe[k] <= '0;
        dlyPIm[k] <= '0;
        dlyE[k]   <= '0;
      end
    end else if (strobe.shiftEn) begin
      dlyI[0]   <= sampleI;
      dlyQ[0]   <= sampleQ;
      dlyPRe[0] <= pRe;
      dlyPIm[0] <= pIm;
      dlyE[0]   <= eTerm;
      for (int k = 1; k < LAG; k++) begin
        dlyI[k]   <= dlyI[k-1];
        dlyQ[k]   <= dlyQ[k-1];
        dlyPRe[k] <= dlyPRe[k-1];
        dlyPIm[k] <= dlyPIm[k-1];
        dlyE[k]   <= dlyE[k-1];
      end
    end
  end

  // Running sums: add the entering term, drop the one leaving the window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cRe  <= '0;
      cIm  <= '0;
      eSum <= '0;
    end else if (strobe.shiftEn) begin
      cRe  <= cRe + CW'(pRe) - CW'(dlyPRe[LAG-1]);
      cIm  <= cIm + CW'(pIm) - CW'(dlyPIm[LAG-1]);
      eSum <= eSum + CW'(eTerm) - CW'(dlyE[LAG-1]);
    end
  end

  // Division-free normalised test: |C|^2 * 2^THR_W > thr * E^2
  logic signed [LW-1:0] cReW, cImW, eW, thrW, magSq, lhs, rhs;
  logic hitRaw;

  always_comb begin
    cReW   = LW'(cRe);
    cImW   = LW'(cIm);
    eW     = LW'(eSum);
    thrW   = LW'($signed({1'b0, thrIn}));
    magSq  = cReW * cReW + cImW * cImW;
    lhs    = magSq <<< THR_W;
    rhs    = eW * eW * thrW;
    hitRaw = lhs > rhs;
  end

  assign hit = strobe.evalEn & hitRaw;

  // R10: without a sample the window sums hold
  a_r10_sums_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> ($stable(cRe) && $stable(cIm) && $stable(eSum)));

  // R5: an empty window cannot pass the test
  a_r5_zero_energy: assert property (@(posedge clk) disable iff (!rstN)
    (eSum == '0) |-> !hitRaw);

endmodule

// File: rtl/acorr_control.sv
module acorr_control
  import pktdet_pkg::*;
#(
  parameter int LAG = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  input  logic         clrIn,
  input  logic         hit,
  output acorrStrobe_t strobe,
  output logic         detFlag
);
  localparam int FILL  = 2 * LAG;              // delay line plus one window
  localparam int CNT_W = $clog2(FILL + 1);

  logic [CNT_W-1:0] fillCnt;
  logic             fillDone;
  logic             evalPend;

  assign fillDone = (fillCnt == CNT_W'(FILL));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt  <= '0;
      evalPend <= 1'b0;
    end else begin
      evalPend <= validIn;
      if (validIn && !fillDone) fillCnt <= fillCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.shiftEn = validIn;
    strobe.evalEn  = evalPend;
  end

  // Sticky flag, clear has priority over a set
  always_ff @(posedge clk) begin
    if (!rstN)                    detFlag <= 1'b0;
    else if (clrIn)               detFlag <= 1'b0;
    else if (hit && fillDone)     detFlag <= 1'b1;
  end

  // R7: flag holds unless its receiver clears it
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (detFlag && !clrIn) |=> detFlag);

  // R8: a clear always wins
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    clrIn |=> !detFlag);

  // R6: no detection while the window is still filling
  a_r6_no_early_detect: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detFlag) |-> fillDone);

  // R9: a decision is only taken one cycle after a sample
  a_r9_eval_after_shift: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evalEn |-> $past(strobe.shiftEn));

endmodule

// File: rtl/pkt_detect_dual.sv
module pkt_detect_dual
  import pktdet_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int THR_W    = 8,
  parameter int LAG_OFDM = 16,
  parameter int LAG_DSSS = 20
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       validIn,
  input  logic signed [SAMPLE_W-1:0] sampleI,
  input  logic signed [SAMPLE_W-1:0] sampleQ,
  input  logic [THR_W-1:0]           thrOfdm,
  input  logic [THR_W-1:0]           thrDsss,
  input  logic                       clrOfdm,
  input  logic                       clrDsss,
  output logic                       detOfdm,
  output logic                       detDsss
);
  logic [NUM_DET-1:0]            clrVec;
  logic [NUM_DET-1:0]            detVec;
  logic [NUM_DET-1:0][THR_W-1:0] thrVec;

  assign clrVec[DET_OFDM] = clrOfdm;
  assign clrVec[DET_DSSS] = clrDsss;
  assign thrVec[DET_OFDM] = thrOfdm;
  assign thrVec[DET_DSSS] = thrDsss;

  for (genvar g = 0; g < NUM_DET; g++) begin : gDet
    localparam int LAG = (g == DET_OFDM) ? LAG_OFDM : LAG_DSSS;
    acorrStrobe_t strobe;
    logic         hit;

    acorr_control #(.LAG(LAG)) uCtrl (
      .clk     (clk),
      .rstN    (rstN),
      .validIn (validIn),
      .clrIn   (clrVec[g]),
      .hit     (hit),
      .strobe  (strobe),
      .detFlag (detVec[g])
    );

    acorr_datapath #(.SAMPLE_W(SAMPLE_W), .LAG(LAG), .THR_W(THR_W)) uDp (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobe),
      .sampleI (sampleI),
      .sampleQ (sampleQ),
      .thrIn   (thrVec[g]),
      .hit     (hit)
    );
  end

  assign detOfdm = detVec[DET_OFDM];
  assign detDsss = detVec[DET_DSSS];

endmodule

// File: tb/tb_pkt_detect_dual.sv
module tb_pkt_detect_dual;
  localparam int SW = 6;
  localparam int TW = 8;
  localparam int LO = 16;
  localparam int LD = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0;
  logic signed [SW-1:0] sampleI = '0, sampleQ = '0;
  logic [TW-1:0] thrOfdm = '0, thrDsss = '0;
  logic clrOfdm = 1'b0, clrDsss = 1'b0;
  logic detOfdm, detDsss;

  always #10 clk = ~clk;

  pkt_detect_dual #(.SAMPLE_W(SW), .THR_W(TW), .LAG_OFDM(LO), .LAG_DSSS(LD)) dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .sampleI(sampleI), .sampleQ(sampleQ),
    .thrOfdm(thrOfdm), .thrDsss(thrDsss), .clrOfdm(clrOfdm), .clrDsss(clrDsss),
    .detOfdm(detOfdm), .detDsss(detDsss));

  int checks = 0, errors = 0;
  bit done = 0;
  int hi [0:255];
  int hq [0:255];
  int nSamp = 0;
  bit expO = 0, expD = 0;
  logic [15:0] lfsr = 16'hACE1;
  int tbl16I [16], tbl16Q [16], tbl20I [20], tbl20Q [20];

  function automatic int nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr[5:0]));
  endfunction

  // Direct window sums from the sample history (R2, R3, R4, R6)
  function automatic bit modelHit(int lag, int thr, int n);
    longint cr = 0, ci = 0, e = 0;
    for (int k = n - lag; k < n; k++) begin
      if (k >= 0) e += hi[k] * hi[k] + hq[k] * hq[k];
      if (k >= lag) begin
        cr += hi[k] * hi[k-lag] + hq[k] * hq[k-lag];
        ci += hq[k] * hi[k-lag] - hi[k] * hq[k-lag];
      end
    end
    return (n >= 2 * lag) && ((cr * cr + ci * ci) * 256 > longint'(thr) * e * e);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (sample %0d)", tag, act, exp, nSamp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; validIn = 1'b0; clrOfdm = 1'b0; clrDsss = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nSamp = 0; expO = 0; expD = 0;
    @(negedge clk);
    chk("R1 ofdm after reset", detOfdm, 1'b0);
    chk("R1 dsss after reset", detDsss, 1'b0);
  endtask

  // One sample; optional clear in the decision cycle; garbage while idle
  task automatic applySample(int si, int sq, bit clrO, bit clrD);
    string tO, tD;
    @(negedge clk);
    validIn = 1'b1; sampleI = SW'(si); sampleQ = SW'(sq);
    @(negedge clk);
    chk("R9 ofdm before second edge", detOfdm, expO);
    chk("R9 dsss before second edge", detDsss, expD);
    validIn = 1'b0;
    sampleI = SW'(nextRand()); sampleQ = SW'(nextRand());   // R10 idle garbage
    clrOfdm = clrO; clrDsss = clrD;
    hi[nSamp] = si; hq[nSamp] = sq; nSamp++;
    if (clrO) expO = 0; else if (modelHit(LO, int'(thrOfdm), nSamp)) expO = 1;
    if (clrD) expD = 0; else if (modelHit(LD, int'(thrDsss), nSamp)) expD = 1;
    tO = (nSamp < 2 * LO) ? "R2,R6 ofdm" : "R2,R4,R10 ofdm";
    tD = (nSamp < 2 * LD) ? "R3,R6 dsss" : "R3,R4,R10 dsss";
    @(negedge clk);
    clrOfdm = 1'b0; clrDsss = 1'b0;
    chk(tO, detOfdm, expO);
    chk(tD, detDsss, expD);
  endtask

  task automatic patSample(int pat, int idx, output int si, output int sq);
    case (pat)
      0: begin si = 0; sq = 0; end
      1: begin si = 13; sq = -7; end
      2: begin si = tbl16I[idx % 16]; sq = tbl16Q[idx % 16]; end
      3: begin si = tbl20I[idx % 20]; sq = tbl20Q[idx % 20]; end
      4: begin si = nextRand(); sq = nextRand(); end
      default: begin
        if (idx < 40) begin si = tbl16I[idx % 16]; sq = tbl16Q[idx % 16]; end
        else begin si = nextRand(); sq = nextRand(); end
      end
    endcase
  endtask

  initial begin
    int thrList [4] = '{0, 64, 200, 255};
    int si, sq;
    for (int k = 0; k < 16; k++) begin tbl16I[k] = nextRand(); tbl16Q[k] = nextRand(); end
    for (int k = 0; k < 20; k++) begin tbl20I[k] = nextRand(); tbl20Q[k] = nextRand(); end

    // Sweep: patterns x thresholds, every sample checked on both flags
    for (int p = 0; p < 6; p++) begin
      for (int t = 0; t < 4; t++) begin
        thrOfdm = TW'(thrList[t]);
        thrDsss = TW'(thrList[3 - t]);
        doReset();
        for (int i = 0; i < 60; i++) begin
          patSample(p, i, si, sq);
          applySample(si, sq, 1'b0, 1'b0);
        end
        if (p == 0) begin
          chk("R5 zero input ofdm", detOfdm, 1'b0);
          chk("R5 zero input dsss", detDsss, 1'b0);
        end
        if (p == 5 && thrList[t] == 255)
          chk("R7 ofdm holds through noise", detOfdm, 1'b1);
      end
    end

    // Periodic input at the maximum threshold must still be found (R4)
    thrOfdm = 8'd255; thrDsss = 8'd255;
    doReset();
    for (int i = 0; i < 2 * LD + 4; i++) applySample(13, -7, 1'b0, 1'b0);
    chk("R4 ofdm periodic at thr 255", detOfdm, 1'b1);
    chk("R4 dsss periodic at thr 255", detDsss, 1'b1);

    // Independent clears (R8)
    @(negedge clk); clrOfdm = 1'b1;
    @(negedge clk); clrOfdm = 1'b0; expO = 0;
    chk("R8 ofdm cleared", detOfdm, 1'b0);
    chk("R8 dsss untouched", detDsss, 1'b1);
    repeat (4) @(negedge clk);
    chk("R10 no re-detect without sample", detOfdm, 1'b0);
    @(negedge clk); clrDsss = 1'b1;
    @(negedge clk); clrDsss = 1'b0; expD = 0;
    chk("R8 dsss cleared", detDsss, 1'b0);
    chk("R8 ofdm untouched", detOfdm, 1'b0);

    // Clear colliding with a set: clear wins for ofdm, dsss sets
    applySample(13, -7, 1'b1, 1'b0);
    chk("R8 clear beats set", detOfdm, 1'b0);
    chk("R7 dsss re-detects", detDsss, 1'b1);
    applySample(13, -7, 1'b0, 1'b0);
    chk("R7 ofdm re-detects", detOfdm, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule